// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine for one DMA channel. Software loads a source address, a destination address, a unit count and a channel control word through a small register port. A separate global word holds the master enable and two fault flags, one for a non-maskable interrupt and one for an address error. Two event inputs can also set those fault flags. When the channel may start and a request is present, the sequencer asks for the bus. Once it holds the grant it moves one unit by reading the source and then writing the destination. After each unit it steps both addresses and lowers the count.

Requests come either from the block itself (auto-request) or from an external request line. The external line is taken as a level, or in burst mode optionally as a rising edge. In cycle-steal mode the bus is given back after every unit. In burst mode the bus is kept until the count runs out or the transfer is stopped. A normal end latches a done flag, which drives the interrupt output when interrupts are enabled. A fault or a cleared enable stops the transfer at the next unit boundary and leaves the remaining count in place, so clearing the cause resumes the transfer.

Top module: `dma_chan_seq`

## Requirements
- R1: A unit is started only when the master enable (global bit 0) and the channel enable (control bit 0) are 1, the NMI flag (global bit 1), the address-error flag (global bit 2) and the done flag (control bit 1) are 0, and the count is nonzero. While any of these fails, no memory cycle is issued.
- R2: With auto-request (control bit 3 = 1) the channel needs no external request and starts as soon as the R1 conditions hold.
- R3: Each unit is a read cycle (memRd) at the source address, followed in the next cycle by a write cycle (memWr) at the destination address. The write carries the data returned during the read. memSize gives the unit size code from control bits 11:10 (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 is treated as 2).
- R4: After each unit the count (register 2) drops by one. Each address (register 0 is the source, register 1 the destination) stays fixed (mode 0 or 3), increases (mode 1) or decreases (mode 2) by the unit size in bytes. The source mode sits in control bits 7:6 and the destination mode in control bits 9:8.
- R5: When the count reaches 0, the done flag is set and the channel stops. The interrupt output equals the done flag ANDed with the interrupt enable (control bit 2).
- R6: The done flag is cleared only by a write of 0 to control bit 1 that follows a read of the control register that returned 1. A write without such a read leaves it set.
- R7: If the NMI flag or the address-error flag becomes 1, or the master enable or the channel enable becomes 0, the transfer stops after the current unit. The bus is released, the done flag stays 0 and the remaining count is kept. Restoring the conditions resumes the transfer from that point.
- R8: In cycle-steal mode (control bit 4 = 0) busReq drops after every unit, so n units take 3n request cycles. In burst mode (control bit 4 = 1) busReq stays high from the first request to the end, so n units take 2n+1 cycles.
- R9: With external requests (control bit 3 = 0), in cycle-steal mode, and in burst mode with edge select (control bit 5) = 0, the request line is taken as a level. No unit starts while it is low. In level burst mode a low line at a unit boundary releases the bus.
- R10: In burst mode with edge select = 1, a request line that is already high does not start a transfer. A rising edge seen while the channel may start runs the whole count, even if the line then falls.
- R11: No memory cycle is issued while busReq is high and busGnt is low.
- R12: A pulse on nmiEvt or addrErrEvt sets the matching global flag. Software writes to the global register (register 4) set or clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms done-flag clearing) |
| regAddr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 global |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | External transfer request |
| busGnt | input | 1 | Bus grant |
| nmiEvt | input | 1 | Sets the NMI flag |
| addrErrEvt | input | 1 | Sets the address-error flag |
| busReq | output | 1 | Bus request |
| memRd | output | 1 | Read cycle strobe |
| memWr | output | 1 | Write cycle strobe |
| memAddr | output | ADDR_W | Memory address |
| memSize | output | 2 | Unit size code |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, sampled in the read cycle |
| intr | output | 1 | Transfer-end interrupt |

## Verification
A register write takes effect at the edge that ends the cycle in which it is driven. The channel then spends one cycle idle and one cycle requesting before the read cycle, and the write cycle comes exactly one cycle after the read. The done flag and the interrupt rise at the edge that ends the last write. A fault raised during a read cycle therefore lets that unit finish and stops before the next one. The bench samples every strobe at the falling edge, pairs each write with the read before it, and compares addresses, data and the number of request cycles with arithmetic predictions (3n or 2n+1). It reads the registers only after the outputs have settled.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  localparam int REG_W = 32;

  localparam logic [2:0] RA_SRC = 3'd0;
  localparam logic [2:0] RA_DST = 3'd1;
  localparam logic [2:0] RA_CNT = 3'd2;
  localparam logic [2:0] RA_CTL = 3'd3;
  localparam logic [2:0] RA_GLB = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seqState_e;

  typedef struct packed {
    logic latchRd;
    logic unitDone;
    logic setDone;
  } ctlStrb_t;

  typedef struct packed {
    logic       chanEn;
    logic       irqEn;
    logic       autoReq;
    logic       burst;
    logic       edgeSel;
    logic [1:0] srcMode;
    logic [1:0] dstMode;
    logic [1:0] unitSize;
  } chanCfg_t;

endpackage

// File: rtl/dmaseq_datapath.sv
module dmaseq_datapath
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              nmiEvt,
  input  logic              addrErrEvt,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] memRdata,
  output chanCfg_t          cfg,
  output logic              startOk,
  output logic              cntLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic              intr
);

  localparam int NUM_PTR = 2;

  logic [ADDR_W-1:0] addrQ [NUM_PTR];
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] rdLatch;
  logic              doneQ;
  logic              readSeen;
  logic              masterEn;
  logic              nmiFlag;
  logic              aeFlag;
  logic [1:0]        sizeEff;
  logic [ADDR_W-1:0] stepBytes;
  logic              ctlWr;
  logic              ctlRd;

  assign ctlWr     = regWrEn && (regAddr == RA_CTL);
  assign ctlRd     = regRdEn && (regAddr == RA_CTL);
  assign sizeEff   = (cfg.unitSize == 2'd3) ? 2'd2 : cfg.unitSize;
  assign stepBytes = ADDR_W'(1) << sizeEff;

  function automatic logic [ADDR_W-1:0] moveAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic [ADDR_W-1:0] d);
    case (mode)
      2'd1:    return a + d;
      2'd2:    return a - d;
      default: return a;
    endcase
  endfunction

  // Source and destination pointers share one structure
  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    logic [1:0] ptrMode;
    assign ptrMode = (g == 0) ? cfg.srcMode : cfg.dstMode;
    always_ff @(posedge clk) begin
      if (!rstN)
        addrQ[g] <= '0;
      else if (regWrEn && (regAddr == 3'(g)))
        addrQ[g] <= regWdata[ADDR_W-1:0];
      else if (strb.unitDone)
        addrQ[g] <= moveAddr(addrQ[g], ptrMode, stepBytes);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cntQ <= '0;
    else if (regWrEn && (regAddr == RA_CNT))
      cntQ <= regWdata[CNT_W-1:0];
    else if (strb.unitDone && (cntQ != '0))
      cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdLatch <= '0;
    else if (strb.latchRd)
      rdLatch <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (ctlWr) begin
      cfg.chanEn   <= regWdata[0];
      cfg.irqEn    <= regWdata[2];
      cfg.autoReq  <= regWdata[3];
      cfg.burst    <= regWdata[4];
      cfg.edgeSel  <= regWdata[5];
      cfg.srcMode  <= regWdata[7:6];
      cfg.dstMode  <= regWdata[9:8];
      cfg.unitSize <= regWdata[11:10];
    end
  end

  // Done flag: set by hardware, cleared by write-0 after a read of 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      readSeen <= 1'b0;
    end else if (strb.setDone) begin
      doneQ    <= 1'b1;
      readSeen <= 1'b0;
    end else if (ctlWr && !regWdata[1] && readSeen) begin
      doneQ    <= 1'b0;
      readSeen <= 1'b0;
    end else if (ctlRd && doneQ) begin
      readSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      nmiFlag  <= 1'b0;
      aeFlag   <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == RA_GLB)) begin
        masterEn <= regWdata[0];
        nmiFlag  <= regWdata[1] | nmiEvt;
        aeFlag   <= regWdata[2] | addrErrEvt;
      end else begin
        nmiFlag  <= nmiFlag | nmiEvt;
        aeFlag   <= aeFlag | addrErrEvt;
      end
    end
  end

  assign startOk  = masterEn && cfg.chanEn && !nmiFlag && !aeFlag && !doneQ && (cntQ != '0);
  assign cntLast  = (cntQ == CNT_W'(1));
  assign memAddr  = strb.latchRd ? addrQ[0] : addrQ[1];
  assign memWdata = rdLatch;
  assign memSize  = sizeEff;
  assign intr     = doneQ && cfg.irqEn;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_SRC: regRdata = REG_W'(addrQ[0]);
      RA_DST: regRdata = REG_W'(addrQ[1]);
      RA_CNT: regRdata = REG_W'(cntQ);
      RA_CTL: regRdata = REG_W'({cfg.unitSize, cfg.dstMode, cfg.srcMode, cfg.edgeSel,
                                 cfg.burst, cfg.autoReq, cfg.irqEn, doneQ, cfg.chanEn});
      RA_GLB: regRdata = REG_W'({aeFlag, nmiFlag, masterEn});
      default: regRdata = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.unitDone && (cntQ != '0) && !(regWrEn && (regAddr == RA_CNT)))
      |=> (cntQ == $past(cntQ) - 1'b1)); // R4

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> doneQ); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !ctlWr) |=> doneQ); // R6

  AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEvt || addrErrEvt) |=> !startOk); // R12

endmodule

// File: rtl/dmaseq_control.sv
module dmaseq_control
  import dmaseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     autoReq,
  input  logic     burst,
  input  logic     edgeSel,
  input  logic     startOk,
  input  logic     cntLast,
  input  logic     dreq,
  input  logic     busGnt,
  output ctlStrb_t strb,
  output logic     busReq,
  output logic     memRd,
  output logic     memWr
);

  seqState_e stateQ, stateNxt;
  logic      dreqPrev;
  logic      edgePend;
  logic      edgeMode;
  logic      reqPresent;
  logic      contReq;
  logic      grantTake;

  assign edgeMode   = burst && edgeSel && !autoReq;
  assign reqPresent = autoReq || (edgeMode ? edgePend : dreq);
  assign contReq    = autoReq || edgeSel || dreq;
  assign grantTake  = (stateQ == ST_REQ) && startOk && busGnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dreqPrev <= 1'b0;
      edgePend <= 1'b0;
    end else begin
      dreqPrev <= dreq;
      if (grantTake)
        edgePend <= 1'b0;
      else
        edgePend <= (edgePend || (dreq && !dreqPrev)) && startOk && edgeMode;
    end
  end

  always_comb begin
    stateNxt = stateQ;
    strb     = '0;
    case (stateQ)
      ST_IDLE: if (startOk && reqPresent) stateNxt = ST_REQ;
      ST_REQ: begin
        if (!startOk)    stateNxt = ST_IDLE;
        else if (busGnt) stateNxt = ST_RD;
      end
      ST_RD: begin
        strb.latchRd = 1'b1;
        stateNxt     = ST_WR;
      end
      ST_WR: begin
        strb.unitDone = 1'b1;
        if (cntLast) begin
          strb.setDone = 1'b1;
          stateNxt     = ST_IDLE;
        end else if (burst && startOk && contReq) begin
          stateNxt = ST_RD;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  assign busReq = (stateQ != ST_IDLE);
  assign memRd  = (stateQ == ST_RD);
  assign memWr  = (stateQ == ST_WR);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr); // R3

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !burst) |=> !busReq); // R8

  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_IDLE) && !startOk) |=> !busReq); // R1

  AST_NO_GNT: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_REQ) && !busGnt) |=> !memRd); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R3

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dreq,
  input  logic              busGnt,
  input  logic              nmiEvt,
  input  logic              addrErrEvt,
  output logic              busReq,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              intr
);

  ctlStrb_t strb;
  chanCfg_t cfg;
  logic     startOk;
  logic     cntLast;

  dmaseq_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .nmiEvt(nmiEvt), .addrErrEvt(addrErrEvt), .strb(strb), .memRdata(memRdata),
    .cfg(cfg), .startOk(startOk), .cntLast(cntLast), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .intr(intr)
  );

  dmaseq_control i_control (
    .clk(clk), .rstN(rstN), .autoReq(cfg.autoReq), .burst(cfg.burst),
    .edgeSel(cfg.edgeSel), .startOk(startOk), .cntLast(cntLast),
    .dreq(dreq), .busGnt(busGnt), .strb(strb), .busReq(busReq),
    .memRd(memRd), .memWr(memWr)
  );

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        dreq = 1'b0, busGnt = 1'b1, nmiEvt = 1'b0, addrErrEvt = 1'b0;
  logic        busReq, memRd, memWr, intr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;

  int total = 0, bad = 0;
  int rdIdx = 0, wrIdx = 0, reqCyc = 0;
  logic [31:0] src0, dst0;
  int srcDelta, dstDelta;
  logic [1:0] curSz;

  always #2 clk = ~clk;

  assign memRdata = memAddr ^ KEY;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dreq(dreq), .busGnt(busGnt),
    .nmiEvt(nmiEvt), .addrErrEvt(addrErrEvt), .busReq(busReq), .memRd(memRd),
    .memWr(memWr), .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .memRdata(memRdata), .intr(intr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expSrc(input int k);
    return src0 + 32'(k * srcDelta);
  endfunction
  function automatic logic [31:0] expDst(input int k);
    return dst0 + 32'(k * dstDelta);
  endfunction
  function automatic int deltaOf(input int mode, input int sz);
    int step = 1 << sz;
    return (mode == 1) ? step : (mode == 2) ? -step : 0;
  endfunction
  function automatic logic [31:0] ctlWord(input bit en, input bit irq, input bit auto_,
                                          input bit burst, input bit edge_, input int sm,
                                          input int dm, input int sz);
    return {20'd0, 2'(sz), 2'(dm), 2'(sm), edge_, burst, auto_, irq, 1'b0, en};
  endfunction

  // Monitor: every strobe sampled at the falling edge (R3, R4, R8)
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq) reqCyc++;
      if (memRd) begin
        chk(memAddr == expSrc(rdIdx), "R4", "read address", memAddr, expSrc(rdIdx));
        chk(memSize == curSz, "R3", "unit size", 32'(memSize), 32'(curSz));
        rdIdx++;
      end
      if (memWr) begin
        chk(rdIdx == wrIdx + 1, "R3", "write follows read", 32'(rdIdx), 32'(wrIdx + 1));
        chk(memAddr == expDst(wrIdx), "R4", "write address", memAddr, expDst(wrIdx));
        chk(memWdata == (expSrc(wrIdx) ^ KEY), "R3", "write data", memWdata,
            expSrc(wrIdx) ^ KEY);
        wrIdx++;
      end
      if (busReq && !busGnt)
        chk(!memRd && !memWr, "R11", "cycle without grant", 32'(memRd), 32'd0);
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    regRdEn = 1'b1; regAddr = a;
    #1 v = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input int sm, input int dm, input int sz);
    src0 = s; dst0 = d; srcDelta = deltaOf(sm, sz); dstDelta = deltaOf(dm, sz);
    curSz = 2'(sz); rdIdx = 0; wrIdx = 0; reqCyc = 0;
    regWrite(3'd0, s);
    regWrite(3'd1, d);
    regWrite(3'd2, 32'(cnt));
    regWrite(3'd4, 32'd1);
  endtask

  task automatic waitIntr(input int maxCyc);
    for (int i = 0; i < maxCyc && !intr; i++) @(negedge clk);
  endtask

  task automatic clearDone();
    logic [31:0] v;
    regRead(3'd3, v);
    regWrite(3'd3, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chk(busReq == 1'b0, "R1", "reset busReq", 32'(busReq), 0);
    chk(intr == 1'b0, "R5", "reset intr", 32'(intr), 0);
    regRead(3'd3, v); chk(v == 0, "R1", "reset control", v, 0);
    regRead(3'd2, v); chk(v == 0, "R4", "reset count", v, 0);

    // R12 / R1: event flag blocks start; master disable blocks start
    setup(32'h100, 32'h900, 2, 1, 1, 2);
    nmiEvt = 1'b1; @(negedge clk); nmiEvt = 1'b0;
    regRead(3'd4, v); chk(v == 3, "R12", "nmi flag set", v, 3);
    regWrite(3'd3, ctlWord(1, 1, 1, 0, 0, 1, 1, 2));
    repeat (20) @(negedge clk);
    chk(rdIdx == 0, "R1", "blocked by nmi", 32'(rdIdx), 0);
    addrErrEvt = 1'b1; @(negedge clk); addrErrEvt = 1'b0;
    regRead(3'd4, v); chk(v == 7, "R12", "addr error flag set", v, 7);
    regWrite(3'd4, 32'd0);
    repeat (20) @(negedge clk);
    chk(rdIdx == 0, "R1", "blocked by master enable", 32'(rdIdx), 0);
    regWrite(3'd4, 32'd1);
    waitIntr(100);
    chk(rdIdx == 2, "R1", "runs once allowed", 32'(rdIdx), 2);

    // R6: write without read keeps done; read then write clears
    regWrite(3'd3, ctlWord(0, 1, 1, 0, 0, 1, 1, 2));
    chk(intr == 1'b1, "R6", "done kept without read", 32'(intr), 1);
    regRead(3'd3, v); chk(v[1] == 1'b1, "R6", "done reads 1", 32'(v[1]), 1);
    regWrite(3'd3, ctlWord(0, 1, 1, 0, 0, 1, 1, 2));
    chk(intr == 1'b0, "R6", "done cleared after read", 32'(intr), 0);
    regRead(3'd3, v); chk(v[1] == 1'b0, "R6", "done reads 0", 32'(v[1]), 0);

    // Sweep: auto request, both bus modes, all address modes and sizes (R2 R4 R5 R8)
    for (int bm = 0; bm < 2; bm++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int sz = 0; sz < 3; sz++) begin
            int n = 3;
            setup(32'h4000 + 32'(sm * 64), 32'h8000 + 32'(dm * 64), n, sm, dm, sz);
            regWrite(3'd3, ctlWord(1, 1, 1, bm[0], 0, sm, dm, sz));
            waitIntr(100);
            chk(rdIdx == n, "R2", "units moved", 32'(rdIdx), 32'(n));
            chk(intr == 1'b1, "R5", "interrupt at end", 32'(intr), 1);
            chk(reqCyc == (bm ? 2 * n + 1 : 3 * n), "R8", "request cycles",
                32'(reqCyc), 32'(bm ? 2 * n + 1 : 3 * n));
            regRead(3'd2, v); chk(v == 0, "R4", "count at end", v, 0);
            regRead(3'd0, v); chk(v == expSrc(n), "R4", "final source", v, expSrc(n));
            regRead(3'd1, v); chk(v == expDst(n), "R4", "final destination", v, expDst(n));
            repeat (5) @(negedge clk);
            chk(rdIdx == n, "R5", "stopped after end", 32'(rdIdx), 32'(n));
            clearDone();
            chk(intr == 1'b0, "R6", "cleared", 32'(intr), 0);
          end

    // R7: abort variants in burst mode, then resume
    for (int vnt = 0; vnt < 4; vnt++) begin
      setup(32'h2000, 32'h3000, 8, 1, 1, 2);
      regWrite(3'd3, ctlWord(1, 1, 1, 1, 0, 1, 1, 2));
      while (!memRd) @(negedge clk);
      case (vnt)
        0: begin nmiEvt = 1'b1; @(negedge clk); nmiEvt = 1'b0; end
        1: begin addrErrEvt = 1'b1; @(negedge clk); addrErrEvt = 1'b0; end
        2: regWrite(3'd4, 32'd0);
        default: regWrite(3'd3, ctlWord(0, 1, 1, 1, 0, 1, 1, 2));
      endcase
      repeat (20) @(negedge clk);
      chk(rdIdx == 1, "R7", "stopped after one unit", 32'(rdIdx), 1);
      chk(busReq == 1'b0, "R7", "bus released", 32'(busReq), 0);
      chk(intr == 1'b0, "R7", "no end interrupt", 32'(intr), 0);
      regRead(3'd2, v); chk(v == 7, "R7", "remaining count", v, 7);
      if (vnt == 3) regWrite(3'd3, ctlWord(1, 1, 1, 1, 0, 1, 1, 2));
      else regWrite(3'd4, 32'd1);
      waitIntr(100);
      chk(rdIdx == 8, "R7", "resumed to end", 32'(rdIdx), 8);
      clearDone();
    end

    // R9: level request in cycle-steal mode
    setup(32'h500, 32'h600, 3, 1, 2, 1);
    regWrite(3'd3, ctlWord(1, 1, 0, 0, 0, 1, 2, 1));
    repeat (20) @(negedge clk);
    chk(rdIdx == 0, "R9", "no start while low", 32'(rdIdx), 0);
    dreq = 1'b1;
    waitIntr(100);
    chk(rdIdx == 3, "R9", "level run", 32'(rdIdx), 3);
    chk(reqCyc == 9, "R8", "cycle-steal cycles", 32'(reqCyc), 9);
    dreq = 1'b0;
    clearDone();

    // R9: level burst releases bus when line falls
    setup(32'h700, 32'h780, 3, 1, 1, 0);
    regWrite(3'd3, ctlWord(1, 1, 0, 1, 0, 1, 1, 0));
    dreq = 1'b1;
    while (!memRd) @(negedge clk);
    dreq = 1'b0;
    repeat (15) @(negedge clk);
    chk(rdIdx == 1, "R9", "level burst paused", 32'(rdIdx), 1);
    chk(busReq == 1'b0, "R9", "bus released on low", 32'(busReq), 0);
    dreq = 1'b1;
    waitIntr(100);
    chk(rdIdx == 3, "R9", "level burst finished", 32'(rdIdx), 3);
    dreq = 1'b0;
    clearDone();

    // R10: edge-detected burst
    setup(32'hA00, 32'hB00, 4, 1, 1, 2);
    dreq = 1'b1;
    repeat (2) @(negedge clk);
    regWrite(3'd3, ctlWord(1, 1, 0, 1, 1, 1, 1, 2));
    repeat (20) @(negedge clk);
    chk(rdIdx == 0, "R10", "level ignored in edge mode", 32'(rdIdx), 0);
    dreq = 1'b0; @(negedge clk);
    dreq = 1'b1; repeat (2) @(negedge clk);
    dreq = 1'b0;
    waitIntr(100);
    chk(rdIdx == 4, "R10", "edge runs whole count", 32'(rdIdx), 4);
    chk(reqCyc == 9, "R10", "single burst tenure", 32'(reqCyc), 9);
    clearDone();

    // R11: grant withheld
    busGnt = 1'b0;
    setup(32'hC00, 32'hD00, 2, 1, 1, 2);
    regWrite(3'd3, ctlWord(1, 1, 1, 0, 0, 1, 1, 2));
    repeat (15) @(negedge clk);
    chk(rdIdx == 0, "R11", "no cycle without grant", 32'(rdIdx), 0);
    chk(busReq == 1'b1, "R11", "request pending", 32'(busReq), 1);
    busGnt = 1'b1;
    waitIntr(100);
    chk(rdIdx == 2, "R11", "runs after grant", 32'(rdIdx), 2);
    clearDone();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule